// File: doc/BRIEF.md
# Receive Queue Index and Address Controller

This block tracks one receive queue that lives in a shared, word-addressed message RAM. It holds no payload. It keeps a put index and a get index, works out the fill level from them, and reports full, watermark and message-lost events. The upstream filter raises a strobe each time it routes an element to this queue. The consumer acknowledges each element it has read, and that acknowledge advances the get index.

Each element takes a number of RAM words set by a 3-bit data-field code. The block turns both indices into RAM word addresses. Each address is the configured base address plus the index times the element size. The result is registered, so the address for the next element to write and the next element to read is ready one cycle after an index changes.

The configuration inputs are the depth, the watermark, the size code and the base address. They are changed only while reset is asserted.

Top module: `rx_queue_ctrl`

## Requirements
- R1: While `rst_ni` is low, the outputs are as follows: both indices are 0, the fill level is 0, `full_o` is low, all three interrupt flags are low, and both addresses are 0.
- R2: A `store_i` pulse is accepted when `full_o` is low. An accepted store advances `put_idx_o` by one. After the value `cfg_depth_i`-1 the index wraps to 0. The depth is 1 to 64.
- R3: An `ack_i` pulse is accepted when `fill_o` is nonzero. An accepted acknowledge advances `get_idx_o` with the same wrap rule. An acknowledge on an empty queue leaves `get_idx_o` and `fill_o` unchanged.
- R4: `fill_o` counts the accepted stores that have not yet been acknowledged. `full_o` is high exactly when `fill_o` equals the depth, and then `put_idx_o` equals `get_idx_o`. `full_o` falls in the cycle after an accepted acknowledge.
- R5: A store while full is dropped and `put_idx_o` does not move. The dropped store sets `irq_o[2]` (message lost). This holds even when an acknowledge arrives in the same cycle.
- R6: `irq_o[1]` (full) is set when an accepted store, with no accepted acknowledge in the same cycle, brings the fill level to the depth.
- R7: `irq_o[0]` (watermark) is set when an accepted store, with no accepted acknowledge in the same cycle, brings the fill level to `cfg_wmark_i`. A watermark of 0 or greater than the depth never sets the flag.
- R8: The three `irq_o` bits are sticky. Writing 1 to bit n of `irq_clr_i` clears bit n. A set event in the same cycle as a clear wins.
- R9: `elem_words_o` gives the element size in RAM words for the size code: 0→4, 1→5, 2→6, 3→7, 4→8, 5→10, 6→14, 7→18.
- R10: `elem_bytes_o` gives the data-field size in bytes for the size code: 0→8, 1→12, 2→16, 3→20, 4→24, 5→32, 6→48, 7→64.
- R11: After each clock edge, `rd_addr_o` equals `cfg_start_i` plus `get_idx_o` × element words, with all three operands taken as they were before that edge. The sum is truncated to ADDR_W bits.
- R12: `wr_addr_o` follows the same rule as R11, using `put_idx_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_start_i | input | ADDR_W | Base RAM word address of the queue |
| cfg_depth_i | input | CNT_W | Queue depth in elements, 1..MAX_DEPTH |
| cfg_wmark_i | input | CNT_W | Watermark fill level; 0 or >depth disables it |
| cfg_size_i | input | 3 | Data-field size code |
| store_i | input | 1 | An element was routed to this queue |
| ack_i | input | 1 | The consumer has read the element at the get index |
| irq_clr_i | input | 3 | Write-1-to-clear for irq_o |
| put_idx_o | output | IDX_W | Put index |
| get_idx_o | output | IDX_W | Get index |
| fill_o | output | CNT_W | Fill level |
| full_o | output | 1 | Queue full status |
| irq_o | output | 3 | Sticky flags: bit0 watermark, bit1 full, bit2 lost |
| elem_words_o | output | 5 | Element size in RAM words |
| elem_bytes_o | output | 7 | Data-field size in bytes |
| wr_addr_o | output | ADDR_W | Registered RAM address at the put index |
| rd_addr_o | output | ADDR_W | Registered RAM address at the get index |

## Verification
The bench runs random store and acknowledge traffic against a behavioural model under several configurations.

- **Store-heavy traffic on the largest depth** wraps both indices and drives many overflows, which separates a correct full/empty decision from an off-by-one in the wrap.
- **Depth 1** checks that the full bit alone tells full from empty when both indices stay at 0.
- **Watermarks of 0, just above the depth, 1, and equal to the depth** check the enable window and the coincidence of the watermark and full events.
- **Sweeping all eight size codes** checks the size tables and the address multiply for every element size.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int unsigned SIZE_CODE_W = 3;
  localparam int unsigned WORDS_W     = 5;
  localparam int unsigned BYTES_W     = 7;
  localparam int unsigned IRQ_N       = 3;

  typedef struct packed {
    logic lost;
    logic full;
    logic wmark;
  } irq_t;

  // small codes step by one word / four bytes, large ones by four words / sixteen bytes
  function automatic logic [WORDS_W-1:0] code_words(input logic [SIZE_CODE_W-1:0] code);
    logic [WORDS_W-1:0] c;
    c = WORDS_W'(code);
    if (code < 3'd5) return 5'd4 + c;
    else             return 5'd10 + ((c - 5'd5) << 2);
  endfunction

  function automatic logic [BYTES_W-1:0] code_bytes(input logic [SIZE_CODE_W-1:0] code);
    logic [BYTES_W-1:0] c;
    c = BYTES_W'(code);
    if (code < 3'd5) return 7'd8 + (c << 2);
    else             return 7'd32 + ((c - 7'd5) << 4);
  endfunction

endpackage

// File: rtl/rxq_index.sv
module rxq_index #(
  parameter int unsigned MAX_DEPTH = 64,
  parameter int unsigned IDX_W     = $clog2(MAX_DEPTH),
  parameter int unsigned CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] depth_i,
  input  logic             store_i,
  input  logic             ack_i,
  output logic [IDX_W-1:0] put_o,
  output logic [IDX_W-1:0] get_o,
  output logic [CNT_W-1:0] fill_o,
  output logic             full_o,
  output logic             store_ok_o,
  output logic             ack_ok_o,
  output logic [CNT_W-1:0] fill_next_o
);

  logic [IDX_W-1:0] put_q, get_q;
  logic             full_q;
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] last_idx;
  logic             st_ok, ak_ok;
  logic [CNT_W-1:0] fill_nx;

  assign last_idx = depth_i - CNT_W'(1);

  always_comb begin
    if (full_q)               fill = depth_i;
    else if (put_q >= get_q)  fill = CNT_W'(put_q) - CNT_W'(get_q);
    else                      fill = depth_i - CNT_W'(get_q) + CNT_W'(put_q);
  end

  assign st_ok   = store_i && !full_q;
  assign ak_ok   = ack_i && (fill != '0);
  assign fill_nx = fill + CNT_W'(st_ok) - CNT_W'(ak_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      put_q  <= '0;
      get_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (st_ok) put_q <= (CNT_W'(put_q) == last_idx) ? '0 : put_q + IDX_W'(1);
      if (ak_ok) get_q <= (CNT_W'(get_q) == last_idx) ? '0 : get_q + IDX_W'(1);
      full_q <= (fill_nx == depth_i);
    end
  end

  assign put_o       = put_q;
  assign get_o       = get_q;
  assign fill_o      = fill;
  assign full_o      = full_q;
  assign store_ok_o  = st_ok;
  assign ack_ok_o    = ak_ok;
  assign fill_next_o = fill_nx;

  a_r4_full_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |-> (put_q == get_q));
  a_r5_put_held_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q |=> $stable(put_q));
  a_r3_empty_ack_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == '0) |=> $stable(get_q));
  a_r2_put_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    CNT_W'(put_q) < depth_i);

endmodule

// File: rtl/rxq_addr.sv
module rxq_addr #(
  parameter int unsigned IDX_W   = 6,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WORDS_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  start_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [WORDS_W-1:0] words_i,
  output logic [ADDR_W-1:0]  addr_o
);

  localparam int unsigned PROD_W = IDX_W + WORDS_W;

  logic [PROD_W-1:0] offs;
  logic [ADDR_W-1:0] addr_q;

  assign offs = PROD_W'(idx_i) * PROD_W'(words_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= start_i + ADDR_W'(offs);
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);

  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_q[g] <= 1'b0;
      else if (set_i[g])  flag_q[g] <= 1'b1;
      else if (clr_i[g])  flag_q[g] <= 1'b0;
    end

    a_r8_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_q[g] && !clr_i[g]) |=> flag_q[g]);
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[g] |=> flag_q[g]);
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/rx_queue_ctrl.sv
module rx_queue_ctrl
  import rxq_pkg::*;
#(
  parameter int unsigned MAX_DEPTH = 64,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IDX_W     = $clog2(MAX_DEPTH),
  parameter int unsigned CNT_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [ADDR_W-1:0]      cfg_start_i,
  input  logic [CNT_W-1:0]       cfg_depth_i,
  input  logic [CNT_W-1:0]       cfg_wmark_i,
  input  logic [SIZE_CODE_W-1:0] cfg_size_i,
  input  logic                   store_i,
  input  logic                   ack_i,
  input  logic [IRQ_N-1:0]       irq_clr_i,
  output logic [IDX_W-1:0]       put_idx_o,
  output logic [IDX_W-1:0]       get_idx_o,
  output logic [CNT_W-1:0]       fill_o,
  output logic                   full_o,
  output logic [IRQ_N-1:0]       irq_o,
  output logic [WORDS_W-1:0]     elem_words_o,
  output logic [BYTES_W-1:0]     elem_bytes_o,
  output logic [ADDR_W-1:0]      wr_addr_o,
  output logic [ADDR_W-1:0]      rd_addr_o
);

  logic [IDX_W-1:0]   put_idx, get_idx;
  logic [CNT_W-1:0]   fill, fill_nx;
  logic               full, st_ok, ak_ok;
  logic               wm_en, grow;
  logic [WORDS_W-1:0] words;
  irq_t               irq_set;
  logic [IRQ_N-1:0]   irq_q;
  logic [IDX_W-1:0]   addr_idx [2];
  logic [ADDR_W-1:0]  addr_q   [2];

  rxq_index #(
    .MAX_DEPTH (MAX_DEPTH),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_index (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .depth_i     (cfg_depth_i),
    .store_i     (store_i),
    .ack_i       (ack_i),
    .put_o       (put_idx),
    .get_o       (get_idx),
    .fill_o      (fill),
    .full_o      (full),
    .store_ok_o  (st_ok),
    .ack_ok_o    (ak_ok),
    .fill_next_o (fill_nx)
  );

  assign words        = code_words(cfg_size_i);
  assign elem_words_o = words;
  assign elem_bytes_o = code_bytes(cfg_size_i);

  // index 0 drives the write address, index 1 the read address
  assign addr_idx[0] = put_idx;
  assign addr_idx[1] = get_idx;

  for (genvar p = 0; p < 2; p++) begin : g_addr
    rxq_addr #(
      .IDX_W   (IDX_W),
      .ADDR_W  (ADDR_W),
      .WORDS_W (WORDS_W)
    ) u_addr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (cfg_start_i),
      .idx_i   (addr_idx[p]),
      .words_i (words),
      .addr_o  (addr_q[p])
    );
  end

  assign wm_en = (cfg_wmark_i != '0) && (cfg_wmark_i <= cfg_depth_i);
  assign grow  = st_ok && !ak_ok;

  always_comb begin
    irq_set       = '0;
    irq_set.wmark = grow && wm_en && (fill_nx == cfg_wmark_i);
    irq_set.full  = grow && (fill_nx == cfg_depth_i);
    irq_set.lost  = store_i && full;
  end

  rxq_irq #(
    .N (IRQ_N)
  ) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (irq_set),
    .clr_i  (irq_clr_i),
    .flag_o (irq_q)
  );

  assign put_idx_o = put_idx;
  assign get_idx_o = get_idx;
  assign fill_o    = fill;
  assign full_o    = full;
  assign irq_o     = irq_q;
  assign wr_addr_o = addr_q[0];
  assign rd_addr_o = addr_q[1];

  a_r7_wmark_only_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q[0]) |-> wm_en);
  a_r6_full_irq_with_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q[1]) |-> full);
  a_r5_lost_on_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && full) |=> irq_q[2]);
  a_r4_fill_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= cfg_depth_i);

endmodule

// File: tb/rx_queue_ctrl_bench.sv
module rx_queue_ctrl_bench;

  localparam int MAX_DEPTH = 64;
  localparam int ADDR_W    = 16;
  localparam int IDX_W     = 6;
  localparam int CNT_W     = 7;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] cfg_start_i = '0;
  logic [CNT_W-1:0]  cfg_depth_i = 7'd4;
  logic [CNT_W-1:0]  cfg_wmark_i = '0;
  logic [2:0]        cfg_size_i = '0;
  logic              store_i = 1'b0;
  logic              ack_i = 1'b0;
  logic [2:0]        irq_clr_i = '0;
  logic [IDX_W-1:0]  put_idx_o, get_idx_o;
  logic [CNT_W-1:0]  fill_o;
  logic              full_o;
  logic [2:0]        irq_o;
  logic [4:0]        elem_words_o;
  logic [6:0]        elem_bytes_o;
  logic [ADDR_W-1:0] wr_addr_o, rd_addr_o;

  rx_queue_ctrl #(.MAX_DEPTH(MAX_DEPTH), .ADDR_W(ADDR_W)) u_rx_queue_ctrl (
    .clk_i, .rst_ni, .cfg_start_i, .cfg_depth_i, .cfg_wmark_i, .cfg_size_i,
    .store_i, .ack_i, .irq_clr_i, .put_idx_o, .get_idx_o, .fill_o, .full_o,
    .irq_o, .elem_words_o, .elem_bytes_o, .wr_addr_o, .rd_addr_o
  );

  always #10 clk_i = ~clk_i;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%0d exp=%0d at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  function automatic int ref_words(input int code);
    case (code)
      0: return 4;   1: return 5;   2: return 6;   3: return 7;
      4: return 8;   5: return 10;  6: return 14;  default: return 18;
    endcase
  endfunction

  function automatic int ref_bytes(input int code);
    case (code)
      0: return 8;   1: return 12;  2: return 16;  3: return 20;
      4: return 24;  5: return 32;  6: return 48;  default: return 64;
    endcase
  endfunction

  // behavioural reference
  int m_put, m_get, m_fill, m_rd, m_wr;
  bit m_wm, m_fl, m_lost;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_put = 0; m_get = 0; m_fill = 0; m_rd = 0; m_wr = 0;
      m_wm = 0; m_fl = 0; m_lost = 0;
    end else begin
      int d, w, nf;
      bit s_ok, a_ok, s_wm, s_fl, s_lost;
      d = cfg_depth_i; w = ref_words(cfg_size_i);
      s_ok = store_i && (m_fill < d);
      a_ok = ack_i && (m_fill > 0);
      m_rd = (cfg_start_i + m_get * w) % 65536;
      m_wr = (cfg_start_i + m_put * w) % 65536;
      nf = m_fill + s_ok - a_ok;
      s_wm = s_ok && !a_ok && cfg_wmark_i >= 1 && cfg_wmark_i <= d && nf == cfg_wmark_i;
      s_fl = s_ok && !a_ok && nf == d;
      s_lost = store_i && (m_fill == d);
      m_wm = s_wm || (m_wm && !irq_clr_i[0]);
      m_fl = s_fl || (m_fl && !irq_clr_i[1]);
      m_lost = s_lost || (m_lost && !irq_clr_i[2]);
      if (s_ok) m_put = (m_put + 1 == d) ? 0 : m_put + 1;
      if (a_ok) m_get = (m_get + 1 == d) ? 0 : m_get + 1;
      m_fill = nf;
    end
  end

  task automatic compare_all();
    chk("R2 put_idx", put_idx_o, m_put);
    chk("R3 get_idx", get_idx_o, m_get);
    chk("R4 fill", fill_o, m_fill);
    chk("R4 full", full_o, m_fill == cfg_depth_i);
    chk("R5 irq_lost", irq_o[2], m_lost);
    chk("R6 irq_full", irq_o[1], m_fl);
    chk("R7 irq_wmark", irq_o[0], m_wm);
    chk("R11 rd_addr", rd_addr_o, m_rd);
    chk("R12 wr_addr", wr_addr_o, m_wr);
  endtask

  task automatic do_reset(input int depth, input int wm, input int code, input int start);
    @(negedge clk_i);
    rst_ni = 1'b0;
    store_i = 0; ack_i = 0; irq_clr_i = '0;
    cfg_depth_i = CNT_W'(depth); cfg_wmark_i = CNT_W'(wm);
    cfg_size_i = 3'(code); cfg_start_i = ADDR_W'(start);
    #1;
    chk("R1 put", put_idx_o, 0);
    chk("R1 get", get_idx_o, 0);
    chk("R1 fill", fill_o, 0);
    chk("R1 full", full_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 rd_addr", rd_addr_o, 0);
    chk("R1 wr_addr", wr_addr_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic run(input int n, input int p_st, input int p_ak, input int p_clr);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      compare_all();
      store_i   = ($urandom_range(99) < p_st);
      ack_i     = ($urandom_range(99) < p_ak);
      irq_clr_i = {($urandom_range(99) < p_clr), ($urandom_range(99) < p_clr),
                   ($urandom_range(99) < p_clr)};
    end
    @(negedge clk_i);
    compare_all();
    store_i = 0; ack_i = 0; irq_clr_i = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      n_errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R9 R10: size tables, swept while reset holds the state
    for (int c = 0; c < 8; c++) begin
      cfg_size_i = 3'(c);
      #1;
      chk("R9 elem_words", elem_words_o, ref_words(c));
      chk("R10 elem_bytes", elem_bytes_o, ref_bytes(c));
    end

    // R8 directed: fill depth 2 to full, overflow, then clear each flag
    do_reset(2, 1, 0, 16);
    @(negedge clk_i); store_i = 1;
    @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i); store_i = 0;
    chk("R5 lost set", irq_o[2], 1);
    chk("R6 full set", irq_o[1], 1);
    chk("R7 wmark set", irq_o[0], 1);
    irq_clr_i = 3'b101;
    @(negedge clk_i); irq_clr_i = 3'b000;
    chk("R8 cleared lost", irq_o[2], 0);
    chk("R8 kept full", irq_o[1], 1);
    chk("R8 cleared wmark", irq_o[0], 0);
    store_i = 1; irq_clr_i = 3'b100;
    @(negedge clk_i); store_i = 0; irq_clr_i = 3'b000;
    chk("R8 set beats clear", irq_o[2], 1);
    store_i = 1; ack_i = 1;
    @(negedge clk_i); store_i = 0; ack_i = 0;
    chk("R5 drop with ack put", put_idx_o, 0);
    chk("R3 ack taken", get_idx_o, 1);
    chk("R4 full falls", full_o, 0);

    do_reset(64, 40, 7, 'h100);  run(1500, 70, 30, 3);
    run(1200, 20, 80, 3);
    do_reset(1, 1, 0, 'h40);     run(400, 50, 50, 5);
    do_reset(5, 3, 5, 'h2000);   run(800, 60, 40, 5);
    do_reset(8, 0, 6, 'h300);    run(400, 80, 20, 5);
    do_reset(8, 9, 3, 'h77);     run(400, 80, 20, 5);
    do_reset(13, 13, 2, 'h500);  run(1000, 50, 50, 5);
    do_reset(33, 1, 4, 'hFF00);  run(1000, 55, 45, 5);
    do_reset(3, 2, 1, 'h10);     run(600, 50, 50, 10);
    do_reset(64, 64, 7, 'hFC00); run(1500, 90, 10, 2);

    finish_run();
  end

endmodule